// File: doc/BRIEF.md
# Interrupt Aggregator with NMI Routing

This block gathers up to 32 peripheral interrupt request lines, passes each one through a two-stage synchroniser into the processor clock domain, and drives the result as an interrupt vector toward the processor's interrupt controller. Any single line can also be steered to a non-maskable interrupt output. Software picks the line with a select field and turns the routing on with an enable bit. That enable bit only accepts writes after a three-byte key has been written to an unlock register.

A mode bit switches the vector source between the synchronised hardware lines (normal mode) and a software-owned status register (test mode). In test mode, writing a 1 to a status bit toggles it: a clear bit is raised and a set bit is cleared. Writing a 0 leaves the bit unchanged. This lets firmware raise and retire individual interrupts without any peripheral being involved.

For each line there is a read-only identity register. It holds the sub-source code that the peripheral presented while its request line was last high. All registers are reached over a simple 32-bit register bus. Read data appears one cycle after the request.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, irq_o and nmi_o are 0 and every register reads 0: NMI control at 0x80, status at 0x84, mode at 0x88 and key at 0x8C.
- R2: In normal mode (mode register bit 0 = 0), a change on irq_raw_i appears on irq_o exactly two rising clock edges later.
- R3: In test mode (mode register bit 0 = 1), irq_o shows the status register and ignores irq_raw_i.
- R4: In test mode, a write to 0x84 flips every status bit whose write-data bit is 1 (a clear bit is raised, a set bit is cleared), and leaves alone every bit whose write-data bit is 0.
- R5: A write to 0x84 in normal mode leaves the status register unchanged.
- R6: NMI control at 0x80 has the line select in bits 4:0 and the enable in bit 8. nmi_o equals the enable ANDed with the synchronised line that the select field names. nmi_o is 0 whenever the enable is 0.
- R7: The enable bit changes only while the key is open. Writes to it while the key is locked are ignored, but the select field is written regardless. Reading 0x80 returns {enable at bit 8, select in bits 4:0}.
- R8: The key opens after the bytes 0x59, 0x16 and 0x88 (write-data bits 7:0) are written in that order to 0x8C. A write that breaks the order returns the key to locked, and so does any write to 0x8C while the key is open. Reading 0x8C returns 1 in bit 0 while the key is open.
- R9: Address 4*n (n < 32) reads, in bits 2:0, the sub-source code src_id_i[3n+2:3n] as it was at the last rising edge where irq_raw_i[n] was high. Bus writes to these addresses have no effect.
- R10: Read data appears on rdata_o after the rising edge that accepts the read. Unmapped or unaligned addresses read 0. Reading 0x84 returns irq_o, and reading 0x88 returns the mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_raw_i | input | NUM_IRQ | Raw peripheral interrupt requests |
| src_id_i | input | NUM_IRQ*SRC_W | Sub-source code per line |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Bus write (1) or read (0) |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after request |
| irq_o | output | NUM_IRQ | Interrupt vector to the processor |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
The assertions watch the following on every cycle: the two-edge synchroniser latency in normal mode, the XOR update of the status register and its stability when no test-mode write to it occurs, nmi_o staying low while routing is disabled, the enable bit holding still while the key is locked, and the key relocking after any write while it is open. Some behaviours can only be shown by the bench's scenarios. These are the key's response to broken byte orders, the routing of a chosen line to nmi_o, the select field staying writable while locked, the capture and read-only nature of the identity codes, and the zero value of unmapped reads.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SEL_W   = 5;
  localparam int unsigned MAX_IRQ = 32;
  localparam int unsigned EN_BIT  = 8;

  localparam logic [ADDR_W-1:0] NMI_CTL_ADDR = 8'h80;
  localparam logic [ADDR_W-1:0] STS_ADDR     = 8'h84;
  localparam logic [ADDR_W-1:0] MODE_ADDR    = 8'h88;
  localparam logic [ADDR_W-1:0] KEY_ADDR     = 8'h8C;

  localparam logic [7:0] KEY_B0 = 8'h59;
  localparam logic [7:0] KEY_B1 = 8'h16;
  localparam logic [7:0] KEY_B2 = 8'h88;

  typedef enum logic [1:0] {
    KEY_LOCKED,
    KEY_GOT0,
    KEY_GOT1,
    KEY_OPEN
  } key_state_e;
endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] d_i,
  output logic [NUM_IRQ-1:0] q_o
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/irq_key_fsm.sv
module irq_key_fsm
  import irq_agg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] byte_i,
  output logic       open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_i) begin
      unique case (state_q)
        KEY_LOCKED: state_d = (byte_i == KEY_B0) ? KEY_GOT0 : KEY_LOCKED;
        KEY_GOT0:   state_d = (byte_i == KEY_B1) ? KEY_GOT1 : KEY_LOCKED;
        KEY_GOT1:   state_d = (byte_i == KEY_B2) ? KEY_OPEN : KEY_LOCKED;
        default:    state_d = KEY_LOCKED; // any write while open relocks
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_LOCKED;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == KEY_OPEN);
endmodule

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned SRC_W   = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_IRQ-1:0]       irq_raw_i,
  input  logic [NUM_IRQ*SRC_W-1:0] src_id_i,
  output logic [NUM_IRQ*SRC_W-1:0] src_q_o
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic [SRC_W-1:0] id_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          id_q <= '0;
      else if (irq_raw_i[g]) id_q <= src_id_i[g*SRC_W +: SRC_W];
    end
    assign src_q_o[g*SRC_W +: SRC_W] = id_q;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned SRC_W   = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_IRQ-1:0]       irq_raw_i,
  input  logic [NUM_IRQ*SRC_W-1:0] src_id_i,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [NUM_IRQ-1:0]       irq_o,
  output logic                     nmi_o
);
  localparam int unsigned IDX_W = $clog2(MAX_IRQ);

  logic [NUM_IRQ-1:0]       irq_sync;
  logic [NUM_IRQ*SRC_W-1:0] src_q;
  logic [NUM_IRQ-1:0]       sts_q;
  logic                     mode_q;
  logic                     nmi_en_q;
  logic [SEL_W-1:0]         nmi_sel_q;
  logic                     key_open;

  logic wr, rd, wr_ctl, wr_sts, wr_mode, wr_key;
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign wr_ctl  = wr && (addr_i == NMI_CTL_ADDR);
  assign wr_sts  = wr && (addr_i == STS_ADDR);
  assign wr_mode = wr && (addr_i == MODE_ADDR);
  assign wr_key  = wr && (addr_i == KEY_ADDR);

  irq_sync_chain #(.NUM_IRQ(NUM_IRQ), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_raw_i),
    .q_o   (irq_sync)
  );

  irq_key_fsm u_key (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr_key),
    .byte_i(wdata_i[7:0]),
    .open_o(key_open)
  );

  irq_src_capture #(.NUM_IRQ(NUM_IRQ), .SRC_W(SRC_W)) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_raw_i(irq_raw_i),
    .src_id_i (src_id_i),
    .src_q_o  (src_q)
  );

  // pad to the full 32-entry address space
  logic [MAX_IRQ-1:0] sync_pad;
  logic [SRC_W-1:0]   src_pad [MAX_IRQ];
  for (genvar g = 0; g < MAX_IRQ; g++) begin : g_pad
    if (g < NUM_IRQ) begin : g_used
      assign sync_pad[g] = irq_sync[g];
      assign src_pad[g]  = src_q[g*SRC_W +: SRC_W];
    end else begin : g_unused
      assign sync_pad[g] = 1'b0;
      assign src_pad[g]  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_sel_q <= '0;
      nmi_en_q  <= 1'b0;
      mode_q    <= 1'b0;
      sts_q     <= '0;
    end else begin
      if (wr_ctl) begin
        nmi_sel_q <= wdata_i[SEL_W-1:0];
        if (key_open) nmi_en_q <= wdata_i[EN_BIT];
      end
      if (wr_mode) mode_q <= wdata_i[0];
      if (wr_sts && mode_q) sts_q <= sts_q ^ wdata_i[NUM_IRQ-1:0];
    end
  end

  assign irq_o = mode_q ? sts_q : irq_sync;
  assign nmi_o = nmi_en_q & sync_pad[nmi_sel_q];

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr_i[ADDR_W-1] == 1'b0) begin
      if (addr_i[1:0] == 2'b00)
        rd_mux[SRC_W-1:0] = src_pad[addr_i[IDX_W+1:2]];
    end else begin
      unique case (addr_i)
        NMI_CTL_ADDR: begin
          rd_mux[SEL_W-1:0] = nmi_sel_q;
          rd_mux[EN_BIT]    = nmi_en_q;
        end
        STS_ADDR:  rd_mux[NUM_IRQ-1:0] = irq_o;
        MODE_ADDR: rd_mux[0] = mode_q;
        KEY_ADDR:  rd_mux[0] = key_open;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_IRQ-1:0] irq_raw_i,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [NUM_IRQ-1:0] irq_o,
  input logic               nmi_o,
  input logic               mode_q,
  input logic               key_open,
  input logic               nmi_en_q,
  input logic [NUM_IRQ-1:0] sts_q
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  logic sts_wr;
  assign sts_wr = req_i && we_i && (addr_i == STS_ADDR) && mode_q;

  // R2
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && !mode_q) |-> irq_o == $past(irq_raw_i, 2));

  // R4
  sts_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr |=> sts_q == $past(sts_q ^ wdata_i[NUM_IRQ-1:0]));

  // R5
  sts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_wr |=> $stable(sts_q));

  // R6
  nmi_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nmi_en_q |-> !nmi_o);

  // R7
  nmi_en_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_open |=> $stable(nmi_en_q));

  // R8
  key_relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_open && req_i && we_i && addr_i == KEY_ADDR) |=> !key_open);
endmodule

bind irq_aggregator irq_agg_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_raw_i(irq_raw_i),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .nmi_o    (nmi_o),
  .mode_q   (mode_q),
  .key_open (key_open),
  .nmi_en_q (nmi_en_q),
  .sts_q    (sts_q)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  localparam int NUM_IRQ = 32;
  localparam int SRC_W   = 3;

  logic                     clk_i = 1'b0;
  logic                     rst_ni = 1'b0;
  logic [NUM_IRQ-1:0]       irq_raw_i = '0;
  logic [NUM_IRQ*SRC_W-1:0] src_id_i = '0;
  logic                     req_i = 1'b0;
  logic                     we_i = 1'b0;
  logic [7:0]               addr_i = '0;
  logic [31:0]              wdata_i = '0;
  logic [31:0]              rdata_o;
  logic [NUM_IRQ-1:0]       irq_o;
  logic                     nmi_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  irq_aggregator #(.NUM_IRQ(NUM_IRQ), .SRC_W(SRC_W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_raw_i(irq_raw_i), .src_id_i(src_id_i),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .nmi_o(nmi_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic unlock();
    bus_wr(8'h8C, 32'h59);
    bus_wr(8'h8C, 32'h16);
    bus_wr(8'h8C, 32'h88);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq_o", 32'(irq_o), 32'h0);
    check("R1 nmi_o", 32'(nmi_o), 32'h0);
    bus_rd(8'h80, d); check("R1 nmi ctl", d, 32'h0);
    bus_rd(8'h84, d); check("R1 status", d, 32'h0);
    bus_rd(8'h88, d); check("R1 mode", d, 32'h0);
    bus_rd(8'h8C, d); check("R1 key", d, 32'h0);
  endtask

  task automatic t_sync();
    @(negedge clk_i); irq_raw_i = 32'hA5A5_0001;
    @(negedge clk_i); check("R2 one edge", irq_o, 32'h0);
    @(negedge clk_i); check("R2 two edges", irq_o, 32'hA5A5_0001);
    irq_raw_i = 32'h5A5A_FFFE;
    @(negedge clk_i); check("R2 one edge b", irq_o, 32'hA5A5_0001);
    @(negedge clk_i); check("R2 two edges b", irq_o, 32'h5A5A_FFFE);
  endtask

  task automatic t_nmi();
    logic [31:0] d;
    bus_wr(8'h80, 32'h105);
    bus_rd(8'h80, d); check("R7 en ignored locked", d, 32'h005);
    check("R6 nmi off when disabled", 32'(nmi_o), 32'h0);
    unlock();
    bus_rd(8'h8C, d); check("R8 key open", d, 32'h1);
    bus_wr(8'h80, 32'h105);
    check("R6 nmi line5", 32'(nmi_o), 32'h1);
    bus_rd(8'h80, d); check("R7 en written open", d, 32'h105);
    irq_raw_i = 32'h5A5A_FFDE;
    wait_cyc(2);
    check("R6 nmi follows line5 low", 32'(nmi_o), 32'h0);
    bus_wr(8'h80, 32'h107);
    check("R6 nmi line7", 32'(nmi_o), 32'h1);
  endtask

  task automatic t_key();
    logic [31:0] d;
    bus_wr(8'h8C, 32'h0);
    bus_rd(8'h8C, d); check("R8 relock after open", d, 32'h0);
    bus_wr(8'h80, 32'h003);
    bus_rd(8'h80, d); check("R7 sel writable locked", d, 32'h103);
    check("R6 nmi line3", 32'(nmi_o), 32'h1);
    bus_wr(8'h8C, 32'h59); bus_wr(8'h8C, 32'h17); bus_wr(8'h8C, 32'h88);
    bus_rd(8'h8C, d); check("R8 broken second byte", d, 32'h0);
    bus_wr(8'h8C, 32'h59); bus_wr(8'h8C, 32'h16); bus_wr(8'h8C, 32'h59);
    bus_rd(8'h8C, d); check("R8 broken third byte", d, 32'h0);
    unlock();
    bus_rd(8'h8C, d); check("R8 reopen", d, 32'h1);
    bus_wr(8'h80, 32'h007);
    check("R6 nmi disabled", 32'(nmi_o), 32'h0);
    bus_wr(8'h8C, 32'h59);
    bus_rd(8'h8C, d); check("R8 any write relocks", d, 32'h0);
  endtask

  task automatic t_test_mode();
    logic [31:0] d;
    irq_raw_i = '0;
    wait_cyc(3);
    bus_wr(8'h84, 32'h3);
    bus_rd(8'h84, d); check("R10 status reads irq_o", d, 32'h0);
    bus_wr(8'h88, 32'h1);
    check("R5 normal write ignored", irq_o, 32'h0);
    irq_raw_i = '1;
    wait_cyc(3);
    check("R3 raw ignored", irq_o, 32'h0);
    bus_wr(8'h84, 32'h11);
    check("R4 set", irq_o, 32'h11);
    bus_wr(8'h84, 32'h101);
    check("R4 clear and set", irq_o, 32'h110);
    bus_wr(8'h84, 32'h0);
    check("R4 zero no effect", irq_o, 32'h110);
    bus_rd(8'h84, d); check("R10 status read", d, 32'h110);
    bus_rd(8'h88, d); check("R10 mode read", d, 32'h1);
    bus_wr(8'h88, 32'h0);
    check("R3 back to normal", irq_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_src_id();
    logic [31:0] d;
    irq_raw_i = '0;
    wait_cyc(3);
    src_id_i[3*SRC_W +: SRC_W]  = 3'd5;
    src_id_i[31*SRC_W +: SRC_W] = 3'd6;
    @(negedge clk_i); irq_raw_i = 32'h8000_0008;
    @(negedge clk_i); irq_raw_i = '0;
    src_id_i[3*SRC_W +: SRC_W]  = 3'd2;
    src_id_i[31*SRC_W +: SRC_W] = 3'd1;
    wait_cyc(1);
    bus_rd(8'h0C, d); check("R9 line3 captured", d, 32'h5);
    bus_rd(8'h7C, d); check("R9 line31 captured", d, 32'h6);
    bus_wr(8'h0C, 32'h7);
    bus_rd(8'h0C, d); check("R9 write ignored", d, 32'h5);
    bus_rd(8'h90, d); check("R10 unmapped", d, 32'h0);
    bus_rd(8'h0D, d); check("R10 unaligned", d, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %h expected %h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(1);
    t_reset();
    t_sync();
    t_nmi();
    t_key();
    t_test_mode();
    t_src_id();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule